// File: doc/BRIEF.md
# CardBus Socket Event and Power Control Register Bank

This block holds the per-socket status and power-control state of one CardBus slot, reached through a word-indexed register read/write port. It watches the card status-change pin and the two card-detect pins, each through a synchronizer, plus a synchronous power-cycle-done strobe. A change on any of them sets a sticky event bit that software clears by writing a one to it. An event bit whose enable is set raises the status-change interrupt.

The bank also stores enable bits and a force register that can only turn enables on. It presents a read-only view of card type and voltage capability, and drives the Vpp and Vcc select codes toward the external power switch. A Vcc request that is illegal or that the inserted card cannot accept is refused. The refusal is recorded in a flag.

Top module: `cb_sock_regs`

## Requirements
- R1: After reset every register reads zero except the level inputs reflected in the status register (word 2), `irq_o` is 0, and `vpp_sel_o` and `vcc_sel_o` are 000.
- R2: Event register (word 0) bit 0 sets when the synchronized status-change level changes, bit 1 on a change of card-detect 1, bit 2 on a change of card-detect 2, and bit 3 one cycle after `pwr_done_i` is high. Bits 31..4 read zero. A held level sets nothing further.
- R3: Writing a 1 to a bit of word 0 or of word 2 in bits 3..0 clears that event bit. Writing 0 leaves it unchanged.
- R4: When a hardware set and a write-one-to-clear hit the same event bit in one cycle, the bit ends set.
- R5: Status register (word 2) bits 3..0 mirror the event bits. Bit 4 is a 16-bit card, bit 5 is a CardBus card, bit 6 is the card interrupt pin, bit 7 is an unknown card type, bit 10 is card accepts 5.0 V, bit 11 is card accepts 3.3 V, bit 28 is socket accepts 5.0 V and bit 29 is socket accepts 3.3 V. All other bits read zero except bit 9 (R10).
- R6: The enable register (word 1) stores bits 0..6, 14 and 15 as written. Its other bits read zero.
- R7: Writing the force register (word 3) ORs written bits 0..4 and 15 into the enable register and never clears an enable bit. Word 3 reads zero.
- R8: `irq_o` is 1 exactly when some event bit i in 0..3 is set together with enable bit i.
- R9: Control register (word 4) bits 2..0 hold the Vpp code (000 off, 001 12.0 V, 010 5.0 V, 011 3.3 V) and drive `vpp_sel_o`. A Vpp code 100..111 leaves Vpp unchanged.
- R10: Control bits 6..4 hold the Vcc code and drive `vcc_sel_o`. A Vcc code that is 001, or 1xx, or 010 without card 5.0 V support, or 011 without card 3.3 V support, leaves Vcc unchanged and sets status bit 9. An accepted Vcc write clears bit 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Register access strobe |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Word index of the register |
| req_wdata_i | input | 32 | Write data |
| req_rdata_o | output | 32 | Read data for `req_addr_i`, combinational |
| stschg_i | input | 1 | Card status-change pin, asynchronous |
| cdet1_i | input | 1 | Card-detect 1 pin, asynchronous |
| cdet2_i | input | 1 | Card-detect 2 pin, asynchronous |
| pwr_done_i | input | 1 | Power-cycle-complete strobe, synchronous |
| card16_i | input | 1 | 16-bit card present |
| cardbus_i | input | 1 | CardBus card present |
| card_irq_i | input | 1 | Card interrupt pin asserted |
| card_unk_i | input | 1 | Card present, type unknown |
| card_5v_i | input | 1 | Card accepts 5.0 V |
| card_3v_i | input | 1 | Card accepts 3.3 V |
| sock_5v_i | input | 1 | Socket accepts 5.0 V |
| sock_3v_i | input | 1 | Socket accepts 3.3 V |
| irq_o | output | 1 | Status-change interrupt |
| vpp_sel_o | output | 3 | Vpp select code |
| vcc_sel_o | output | 3 | Vcc select code |

## Verification
Every cycle, the assertions check four things. An event bit only rises where a set was raised. A set beats a same-cycle clear. A force write never drops an enable bit. The Vcc output only ever carries an allowed code and holds when a request is refused. The directed scenarios are the only place to show the synchronizer latency, the bit positions of the status view and the exact read values. They also show how refused writes interact with card capability and how the interrupt follows enable changes.

// File: rtl/cb_sock_pkg.sv
package cb_sock_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned N_EV   = 4;
  localparam int unsigned SEL_W  = 3;

  typedef enum logic [2:0] {
    REG_EVENT = 3'd0,
    REG_ENA   = 3'd1,
    REG_STAT  = 3'd2,
    REG_FORCE = 3'd3,
    REG_CTRL  = 3'd4
  } reg_sel_e;

  // enable bits that hold state / that force may set
  localparam logic [15:0] ENA_WR_MASK   = 16'hC07F;
  localparam logic [15:0] FORCE_WR_MASK = 16'h801F;

  localparam logic [SEL_W-1:0] PWR_OFF = 3'b000;
  localparam logic [SEL_W-1:0] PWR_12V = 3'b001;
  localparam logic [SEL_W-1:0] PWR_5V  = 3'b010;
  localparam logic [SEL_W-1:0] PWR_3V  = 3'b011;

  localparam int unsigned STAT_BAD_VCC = 9;
endpackage

// File: rtl/cb_sock_sync.sv
module cb_sock_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/cb_sock_events.sv
module cb_sock_events #(
  parameter int unsigned N_LVL = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_LVL-1:0] lvl_i,
  input  logic             strb_i,
  input  logic [N_LVL:0]   clr_i,
  output logic [N_LVL:0]   ev_o
);
  localparam int unsigned N_EV = N_LVL + 1;

  logic [N_LVL-1:0] prev_q;
  logic [N_EV-1:0]  set_w;
  logic [N_EV-1:0]  ev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;
  end

  assign set_w = {strb_i, lvl_i ^ prev_q};

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ev_q <= '0;
    else         ev_q <= (ev_q & ~clr_i) | set_w;
  end

  assign ev_o = ev_q;

  // R2
  ev_only_on_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((ev_q & ~$past(ev_q) & ~$past(set_w)) == '0));

  // R4
  ev_set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((set_w & clr_i) != '0) |=> ((ev_q & $past(set_w & clr_i)) == $past(set_w & clr_i)));

  // R3
  ev_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~set_w) != '0) |=> ((ev_q & $past(clr_i & ~set_w)) == '0));
endmodule

// File: rtl/cb_sock_power.sv
module cb_sock_power
  import cb_sock_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [SEL_W-1:0] vpp_req_i,
  input  logic [SEL_W-1:0] vcc_req_i,
  input  logic             card_5v_i,
  input  logic             card_3v_i,
  output logic [SEL_W-1:0] vpp_o,
  output logic [SEL_W-1:0] vcc_o,
  output logic             bad_o
);
  logic [SEL_W-1:0] vpp_q, vcc_q;
  logic             bad_q;
  logic             vpp_ok, vcc_ok;

  assign vpp_ok = ~vpp_req_i[2];

  always_comb begin
    unique case (vcc_req_i)
      PWR_OFF: vcc_ok = 1'b1;
      PWR_5V:  vcc_ok = card_5v_i;
      PWR_3V:  vcc_ok = card_3v_i;
      default: vcc_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vpp_q <= PWR_OFF;
      vcc_q <= PWR_OFF;
      bad_q <= 1'b0;
    end else if (wr_i) begin
      if (vpp_ok) vpp_q <= vpp_req_i;
      if (vcc_ok) vcc_q <= vcc_req_i;
      bad_q <= ~vcc_ok;
    end
  end

  assign vpp_o = vpp_q;
  assign vcc_o = vcc_q;
  assign bad_o = bad_q;

  // R10
  vcc_refuse_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !vcc_ok) |=> (vcc_o == $past(vcc_o)) && bad_o);

  // R10
  vcc_code_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vcc_o != PWR_12V) && !vcc_o[2]);

  // R9
  vpp_code_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vpp_o[2]);
endmodule

// File: rtl/cb_sock_regs.sv
module cb_sock_regs
  import cb_sock_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_wr_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [31:0]       req_wdata_i,
  output logic [31:0]       req_rdata_o,
  input  logic              stschg_i,
  input  logic              cdet1_i,
  input  logic              cdet2_i,
  input  logic              pwr_done_i,
  input  logic              card16_i,
  input  logic              cardbus_i,
  input  logic              card_irq_i,
  input  logic              card_unk_i,
  input  logic              card_5v_i,
  input  logic              card_3v_i,
  input  logic              sock_5v_i,
  input  logic              sock_3v_i,
  output logic              irq_o,
  output logic [2:0]        vpp_sel_o,
  output logic [2:0]        vcc_sel_o
);
  localparam int unsigned N_LVL = N_EV - 1;

  logic             hit;
  reg_sel_e         sel;
  logic             wr_ev, wr_ena, wr_stat, wr_force, wr_ctrl;
  logic [N_LVL-1:0] lvl_raw, lvl_sync;
  logic [N_EV-1:0]  ev_clr, ev;
  logic [15:0]      ena_q;
  logic             bad_vcc;
  logic [31:0]      stat_w;
  logic             unused_w;

  assign hit = (req_addr_i[ADDR_W-1:3] == '0);
  assign sel = reg_sel_e'(req_addr_i[2:0]);

  always_comb begin
    wr_ev = 1'b0; wr_ena = 1'b0; wr_stat = 1'b0; wr_force = 1'b0; wr_ctrl = 1'b0;
    if (req_valid_i && req_wr_i && hit) begin
      unique case (sel)
        REG_EVENT: wr_ev    = 1'b1;
        REG_ENA:   wr_ena   = 1'b1;
        REG_STAT:  wr_stat  = 1'b1;
        REG_FORCE: wr_force = 1'b1;
        REG_CTRL:  wr_ctrl  = 1'b1;
        default: ;
      endcase
    end
  end

  assign lvl_raw = {cdet2_i, cdet1_i, stschg_i};

  cb_sock_sync #(.WIDTH(N_LVL), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (lvl_raw),
    .q_o    (lvl_sync)
  );

  assign ev_clr = (wr_ev || wr_stat) ? req_wdata_i[N_EV-1:0] : '0;

  cb_sock_events #(.N_LVL(N_LVL)) u_events (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (lvl_sync),
    .strb_i (pwr_done_i),
    .clr_i  (ev_clr),
    .ev_o   (ev)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ena_q <= '0;
    else if (wr_ena)   ena_q <= req_wdata_i[15:0] & ENA_WR_MASK;
    else if (wr_force) ena_q <= ena_q | (req_wdata_i[15:0] & FORCE_WR_MASK);
  end

  cb_sock_power u_power (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_ctrl),
    .vpp_req_i (req_wdata_i[2:0]),
    .vcc_req_i (req_wdata_i[6:4]),
    .card_5v_i (card_5v_i),
    .card_3v_i (card_3v_i),
    .vpp_o     (vpp_sel_o),
    .vcc_o     (vcc_sel_o),
    .bad_o     (bad_vcc)
  );

  always_comb begin
    stat_w       = '0;
    stat_w[3:0]  = ev;
    stat_w[4]    = card16_i;
    stat_w[5]    = cardbus_i;
    stat_w[6]    = card_irq_i;
    stat_w[7]    = card_unk_i;
    stat_w[STAT_BAD_VCC] = bad_vcc;
    stat_w[10]   = card_5v_i;
    stat_w[11]   = card_3v_i;
    stat_w[28]   = sock_5v_i;
    stat_w[29]   = sock_3v_i;
  end

  always_comb begin
    req_rdata_o = '0;
    if (hit) begin
      unique case (sel)
        REG_EVENT: req_rdata_o = {28'b0, ev};
        REG_ENA:   req_rdata_o = {16'b0, ena_q};
        REG_STAT:  req_rdata_o = stat_w;
        REG_CTRL:  req_rdata_o = {25'b0, vcc_sel_o, 1'b0, vpp_sel_o};
        default:   req_rdata_o = '0;
      endcase
    end
  end

  assign irq_o = |(ev & ena_q[N_EV-1:0]);

  assign unused_w = ^req_wdata_i[31:16];

  // R7
  force_never_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_force |=> ((ena_q & $past(ena_q)) == $past(ena_q)));

  // R6
  ena_reserved_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ena_q & ~ENA_WR_MASK) == 16'h0);

  // R8
  irq_needs_event_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (ev != '0) && (ena_q[N_EV-1:0] != '0));
endmodule

// File: tb/cb_sock_regs_tb.sv
module cb_sock_regs_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic        valid = 0, wr = 0;
  logic [3:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic        stschg = 0, cdet1 = 0, cdet2 = 0, pwr_done = 0;
  logic        card16 = 0, cardbus = 0, card_irq = 0, card_unk = 0;
  logic        card_5v = 0, card_3v = 0, sock_5v = 0, sock_3v = 0;
  logic        irq;
  logic [2:0]  vpp, vcc;

  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cb_sock_regs u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_wr_i(wr),
    .req_addr_i(addr), .req_wdata_i(wdata), .req_rdata_o(rdata),
    .stschg_i(stschg), .cdet1_i(cdet1), .cdet2_i(cdet2), .pwr_done_i(pwr_done),
    .card16_i(card16), .cardbus_i(cardbus), .card_irq_i(card_irq), .card_unk_i(card_unk),
    .card_5v_i(card_5v), .card_3v_i(card_3v), .sock_5v_i(sock_5v), .sock_3v_i(sock_3v),
    .irq_o(irq), .vpp_sel_o(vpp), .vcc_sel_o(vcc)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); valid = 1; wr = 1; addr = a; wdata = d;
    @(negedge clk); valid = 0; wr = 0; wdata = 0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd_reg(0, d); chk("R1 event", d, 0);
    rd_reg(1, d); chk("R1 enable", d, 0);
    rd_reg(2, d); chk("R1 status", d, 0);
    rd_reg(4, d); chk("R1 ctrl", d, 0);
    chk("R1 irq", irq, 0);
    chk("R1 vpp/vcc", {vpp, vcc}, 0);
  endtask

  task automatic t_events;
    logic [31:0] d;
    stschg = 1; idle(4);
    rd_reg(0, d); chk("R2 stschg change", d, 32'h1);
    cdet1 = 1; idle(4);
    rd_reg(0, d); chk("R2 cdet1 change", d, 32'h3);
    cdet2 = 1; idle(4);
    rd_reg(0, d); chk("R2 cdet2 change", d, 32'h7);
    @(negedge clk); pwr_done = 1; @(negedge clk); pwr_done = 0;
    rd_reg(0, d); chk("R2 pwr done strobe", d, 32'hF);
    wr_reg(0, 32'hF); idle(4);
    rd_reg(0, d); chk("R2 held level sets nothing", d, 0);
    cdet1 = 0; idle(4);
    rd_reg(0, d); chk("R2 falling change", d, 32'h2);
    wr_reg(0, 32'hFFFF_FFFF);
  endtask

  task automatic t_w1c;
    logic [31:0] d;
    stschg = 0; cdet2 = 0; idle(4);
    rd_reg(0, d); chk("R2 two changes", d, 32'h5);
    wr_reg(0, 32'h4);
    rd_reg(0, d); chk("R3 clear one bit", d, 32'h1);
    wr_reg(0, 32'h0);
    rd_reg(0, d); chk("R3 zero write no effect", d, 32'h1);
    wr_reg(2, 32'h1);
    rd_reg(0, d); chk("R3 clear via status word", d, 32'h0);
  endtask

  task automatic t_set_wins;
    logic [31:0] d;
    @(negedge clk); pwr_done = 1; @(negedge clk); pwr_done = 0;
    rd_reg(0, d); chk("R4 pre", d, 32'h8);
    @(negedge clk); pwr_done = 1; valid = 1; wr = 1; addr = 0; wdata = 32'h8;
    @(negedge clk); pwr_done = 0; valid = 0; wr = 0; wdata = 0;
    rd_reg(0, d); chk("R4 set beats clear", d, 32'h8);
    wr_reg(0, 32'h8);
    rd_reg(0, d); chk("R4 later clear", d, 32'h0);
  endtask

  task automatic t_status;
    logic [31:0] d;
    card16 = 1; card_irq = 1; card_5v = 1; sock_3v = 1;
    cdet1 = 1; idle(4);
    rd_reg(2, d); chk("R5 status bits a", d, 32'h2000_0452);
    card16 = 0; card_irq = 0; card_5v = 0; sock_3v = 0;
    cardbus = 1; card_unk = 1; card_3v = 1; sock_5v = 1;
    #1 rd_reg(2, d); chk("R5 status bits b", d, 32'h1000_08A2);
    wr_reg(2, 32'hF);
    cardbus = 0; card_unk = 0; card_3v = 0; sock_5v = 0;
    rd_reg(2, d); chk("R5 cleared", d, 0);
  endtask

  task automatic t_enable_force;
    logic [31:0] d;
    wr_reg(1, 32'hFFFF_FFFF);
    rd_reg(1, d); chk("R6 writable bits", d, 32'hC07F);
    wr_reg(1, 32'h0040);
    wr_reg(3, 32'hFFFF_8001);
    rd_reg(1, d); chk("R7 force sets", d, 32'h8041);
    wr_reg(3, 32'h0);
    rd_reg(1, d); chk("R7 force zero no clear", d, 32'h8041);
    wr_reg(3, 32'h0060);
    rd_reg(1, d); chk("R7 non-forceable bit", d, 32'h8041);
    wr_reg(3, 32'h001E);
    rd_reg(1, d); chk("R7 low force bits", d, 32'h805F);
    rd_reg(3, d); chk("R7 force reads zero", d, 0);
    wr_reg(1, 0);
  endtask

  task automatic t_irq;
    logic [31:0] d;
    cdet1 = 0; idle(4);
    #1 chk("R8 event without enable", irq, 0);
    wr_reg(1, 32'h0001);
    chk("R8 other enable", irq, 0);
    wr_reg(1, 32'h0002);
    chk("R8 matching enable", irq, 1);
    wr_reg(0, 32'h2);
    chk("R8 cleared", irq, 0);
    @(negedge clk); pwr_done = 1; @(negedge clk); pwr_done = 0;
    chk("R8 no enable for bit3", irq, 0);
    wr_reg(3, 32'h8);
    chk("R8 forced enable", irq, 1);
    wr_reg(0, 32'hF); wr_reg(1, 0);
    rd_reg(0, d); chk("R8 events gone", d, 0);
  endtask

  task automatic t_power;
    logic [31:0] d;
    card_3v = 1; card_5v = 0;
    wr_reg(4, 32'h31);
    chk("R9 vpp 12V", vpp, 3'b001);
    chk("R10 vcc 3.3V", vcc, 3'b011);
    rd_reg(4, d); chk("R9 ctrl read", d, 32'h31);
    wr_reg(4, 32'h36);
    chk("R9 reserved vpp held", vpp, 3'b001);
    rd_reg(2, d); chk("R10 flag clear on good", d[9], 0);
    wr_reg(4, 32'h22);
    chk("R10 5V refused vcc", vcc, 3'b011);
    chk("R9 vpp still updates", vpp, 3'b010);
    rd_reg(2, d); chk("R10 flag set", d[9], 1);
    wr_reg(4, 32'h10);
    chk("R10 12V refused", vcc, 3'b011);
    wr_reg(4, 32'h50);
    chk("R10 reserved refused", vcc, 3'b011);
    rd_reg(2, d); chk("R10 flag held", d[9], 1);
    card_5v = 1;
    wr_reg(4, 32'h20);
    chk("R10 5V accepted", vcc, 3'b010);
    rd_reg(2, d); chk("R10 flag cleared", d[9], 0);
    wr_reg(4, 32'h00);
    chk("R10 off", {vpp, vcc}, 0);
  endtask

  initial begin
    fork
      begin
        idle(3); rst_n = 1; idle(2);
        t_reset();
        t_events();
        t_w1c();
        t_set_wins();
        t_status();
        t_enable_force();
        t_irq();
        t_power();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule